// File: doc/BRIEF.md
# Self-Invalidating Word Coherence Controller

This block keeps the coherence state of every word in a small private first-level data array. The scheme it serves has no invalidation messages. Each word is Invalid, Valid or Registered, and no transient states exist. A store claims ownership at the shared level through a registration request and waits for that request to be acknowledged. A load to an Invalid word fetches the word through a miss request and its fill. Stale copies are removed locally. At the end of a parallel phase, a sweep drops every Valid word whose region is marked as written in that phase.

Inside critical sections, an atomic load first asks an external access signature whether the word may have been written by the previous holder of the lock. The answer can force the local Valid copy to be dropped and refetched. A touched bit on each word stops this check from repeating. A critical-section-start strobe clears every touched bit. The controller handles one operation at a time and holds a busy flag while it waits.

Top module: `selfinv_coh_ctrl`

## Requirements
- R1: After reset every word is Invalid (code 00) and untouched, and all outputs are low. Valid is code 01 and Registered is code 10. Code 11 never occurs.
- R2: A store to an Invalid or Valid word makes it Registered when the store is accepted. It then holds `reg_req_valid` with the word address and the core id until `reg_ack`. `core_done` pulses in the cycle after the ack edge. A store to a word that is already Registered completes in the next cycle and sends no request.
- R3: A load to an Invalid word holds `miss_req_valid` with the word address until `miss_fill`. The word then becomes Valid and takes the load's region, and `core_done` pulses in the cycle after the fill edge.
- R4: A plain load to a Valid or Registered word pulses `core_done` in the cycle after acceptance and issues no request.
- R5: A `phase_end` seen while idle starts a sweep of one row per cycle, with ROWS rows in all. The sweep turns Invalid every Valid word whose region bit in `phase_wmask` is set. Registered words and words in unmasked regions keep their state. `sweep_done` pulses in the cycle after the last row. A request presented in the same cycle as `phase_end` is not accepted.
- R6: An atomic load to an untouched Valid word raises `sig_query_valid` with the word address in the cycle after acceptance. If `sig_hit` is high, the word becomes Invalid and the load continues as a miss. If it is low, `core_done` pulses in the next cycle.
- R7: An atomic load to a Registered word never queries the signature and never invalidates the word. It completes like a plain hit.
- R8: Every atomic load sets the word's touched bit. A later atomic load to a touched word sends no signature query and behaves like a plain load.
- R9: `cs_start` clears every touched bit. It takes precedence over a touched bit being set in the same cycle.
- R10: Only one registration, miss, signature query or sweep is in flight at a time. `core_busy` is high for all of it, and requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core operation presented this cycle |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_atomic | input | 1 | Load belongs to a critical section |
| core_req_addr | input | log2(ROWS*COLS) | Word index |
| core_req_region | input | log2(NUM_REGIONS) | Region of the accessed word |
| core_busy | output | 1 | Operation or sweep in flight; requests ignored |
| core_done | output | 1 | One-cycle completion pulse |
| reg_req_valid | output | 1 | Registration request to the shared level |
| reg_req_addr | output | log2(ROWS*COLS) | Word being registered |
| reg_req_core | output | CORE_ID_W | Id of this core |
| reg_ack | input | 1 | Registration acknowledged |
| miss_req_valid | output | 1 | Read miss request |
| miss_req_addr | output | log2(ROWS*COLS) | Word being fetched |
| miss_fill | input | 1 | Fill for the outstanding miss |
| phase_end | input | 1 | Parallel phase boundary strobe |
| phase_wmask | input | NUM_REGIONS | Regions written in the ending phase |
| sweep_done | output | 1 | Sweep finished pulse |
| cs_start | input | 1 | Critical section start; clears touched bits |
| sig_query_valid | output | 1 | Signature lookup request |
| sig_query_addr | output | log2(ROWS*COLS) | Word looked up |
| sig_hit | input | 1 | Signature answer, same cycle as the query |

## Verification
On every cycle, the assertions check that word codes stay legal. They check that registration and miss requests stay up with a steady address until answered, and that an answer leads to a completion pulse. They also check that a signature query always resolves in the next cycle and that an idle phase boundary always makes the block busy. Which words a sweep actually drops, the region captured at fill time, and the effect of touched bits across several atomic loads show up only in the bench scenarios. There, a behavioural model follows the word states and predicts whether a later load hits, misses or queries.

// File: rtl/sic_pkg.sv
package sic_pkg;

   typedef enum logic [1:0] {
      WS_INV = 2'b00,
      WS_VAL = 2'b01,
      WS_REG = 2'b10
   } word_st_e;

   typedef enum logic [2:0] {
      C_IDLE,
      C_REGW,
      C_MISS,
      C_SIGQ,
      C_SWEEP
   } ctl_st_e;

endpackage

// File: rtl/sic_word_array.sv
module sic_word_array
   import sic_pkg::*;
#(
   parameter  int ROWS        = 4,
   parameter  int COLS        = 4,
   parameter  int NUM_REGIONS = 4,
   localparam int WORDS       = ROWS * COLS,
   localparam int AW          = $clog2(WORDS),
   localparam int RW          = $clog2(NUM_REGIONS),
   localparam int RRW         = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          rd_addr,
   output word_st_e               rd_state,
   output logic                   rd_touched,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  word_st_e               wr_state,
   input  logic [RW-1:0]          wr_region,
   input  logic                   touch_set,
   input  logic [AW-1:0]          touch_addr,
   input  logic                   touch_clr_all,
   input  logic                   sweep_en,
   input  logic [RRW-1:0]         sweep_row,
   input  logic [NUM_REGIONS-1:0] sweep_mask
);

   word_st_e         st_w [WORDS];
   logic [WORDS-1:0] tch_w;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int IDX = r * COLS + c;

         word_st_e      st_q;
         logic [RW-1:0] rg_q;
         logic          tch_q;
         logic          wr_hit;
         logic          sweep_kill;

         assign wr_hit     = wr_en && (wr_addr == AW'(IDX));
         assign sweep_kill = sweep_en && (sweep_row == RRW'(r)) &&
                             (st_q == WS_VAL) && sweep_mask[rg_q];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_q <= WS_INV;
               rg_q <= '0;
            end else if (wr_hit) begin
               st_q <= wr_state;
               rg_q <= wr_region;
            end else if (sweep_kill) begin
               st_q <= WS_INV;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               tch_q <= 1'b0;
            else if (touch_clr_all)
               tch_q <= 1'b0;
            else if (touch_set && (touch_addr == AW'(IDX)))
               tch_q <= 1'b1;
         end

         assign st_w[IDX]  = st_q;
         assign tch_w[IDX] = tch_q;

         // R1: the unused code never appears in a word
         assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
            logic'(st_q != WS_INV) |-> (st_q == WS_VAL || st_q == WS_REG));
      end
   end

   assign rd_state   = st_w[rd_addr];
   assign rd_touched = tch_w[rd_addr];

endmodule

// File: rtl/sic_sweep_seq.sv
module sic_sweep_seq #(
   parameter  int ROWS        = 4,
   parameter  int NUM_REGIONS = 4,
   localparam int RRW         = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [NUM_REGIONS-1:0] mask_in,
   output logic                   active,
   output logic [RRW-1:0]         row,
   output logic [NUM_REGIONS-1:0] mask,
   output logic                   last,
   output logic                   done
);

   assign last = active && (row == RRW'(ROWS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         row    <= '0;
         mask   <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            active <= 1'b1;
            row    <= '0;
            mask   <= mask_in;
         end else if (active) begin
            if (last) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               row <= row + 1'b1;
            end
         end
      end
   end

   // R5: a finished sweep is followed by no further row activity
   assert_sweep_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |-> !active);

endmodule

// File: rtl/sic_ctrl.sv
module sic_ctrl
   import sic_pkg::*;
#(
   parameter int AW = 4,
   parameter int RW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          core_req_valid,
   input  logic          core_req_write,
   input  logic          core_req_atomic,
   input  logic [AW-1:0] core_req_addr,
   input  logic [RW-1:0] core_req_region,
   input  logic          phase_end,
   output logic          core_busy,
   output logic          core_done,
   output logic          reg_req_valid,
   output logic [AW-1:0] reg_req_addr,
   input  logic          reg_ack,
   output logic          miss_req_valid,
   output logic [AW-1:0] miss_req_addr,
   input  logic          miss_fill,
   output logic          sig_query_valid,
   output logic [AW-1:0] sig_query_addr,
   input  logic          sig_hit,
   input  word_st_e      rd_state,
   input  logic          rd_touched,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output word_st_e      wr_state,
   output logic [RW-1:0] wr_region,
   output logic          touch_set,
   output logic          sweep_start,
   input  logic          sweep_last
);

   ctl_st_e       st_q, st_d;
   logic [AW-1:0] addr_q;
   logic [RW-1:0] region_q;
   logic          done_d;
   logic          accept;

   assign accept = (st_q == C_IDLE) && core_req_valid && !phase_end;

   always_comb begin
      st_d        = st_q;
      done_d      = 1'b0;
      wr_en       = 1'b0;
      wr_addr     = addr_q;
      wr_state    = WS_INV;
      wr_region   = region_q;
      touch_set   = 1'b0;
      sweep_start = 1'b0;
      unique case (st_q)
         C_IDLE: begin
            if (phase_end) begin
               sweep_start = 1'b1;
               st_d        = C_SWEEP;
            end else if (core_req_valid) begin
               if (core_req_write) begin
                  if (rd_state == WS_REG) begin
                     done_d = 1'b1;
                  end else begin
                     wr_en     = 1'b1;
                     wr_addr   = core_req_addr;
                     wr_state  = WS_REG;
                     wr_region = core_req_region;
                     st_d      = C_REGW;
                  end
               end else begin
                  touch_set = core_req_atomic;
                  if (core_req_atomic && !rd_touched && rd_state == WS_VAL)
                     st_d = C_SIGQ;
                  else if (rd_state == WS_INV)
                     st_d = C_MISS;
                  else
                     done_d = 1'b1;
               end
            end
         end
         C_REGW: begin
            if (reg_ack) begin
               done_d = 1'b1;
               st_d   = C_IDLE;
            end
         end
         C_MISS: begin
            if (miss_fill) begin
               wr_en    = 1'b1;
               wr_state = WS_VAL;
               done_d   = 1'b1;
               st_d     = C_IDLE;
            end
         end
         C_SIGQ: begin
            if (sig_hit) begin
               wr_en    = 1'b1;
               wr_state = WS_INV;
               st_d     = C_MISS;
            end else begin
               done_d = 1'b1;
               st_d   = C_IDLE;
            end
         end
         C_SWEEP: begin
            if (sweep_last) st_d = C_IDLE;
         end
         default: st_d = C_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= C_IDLE;
         addr_q    <= '0;
         region_q  <= '0;
         core_done <= 1'b0;
      end else begin
         st_q      <= st_d;
         core_done <= done_d;
         if (accept) begin
            addr_q   <= core_req_addr;
            region_q <= core_req_region;
         end
      end
   end

   assign core_busy       = (st_q != C_IDLE);
   assign reg_req_valid   = (st_q == C_REGW);
   assign miss_req_valid  = (st_q == C_MISS);
   assign sig_query_valid = (st_q == C_SIGQ);
   assign reg_req_addr    = addr_q;
   assign miss_req_addr   = addr_q;
   assign sig_query_addr  = addr_q;

   assert_reg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_valid && !reg_ack |=> reg_req_valid && $stable(reg_req_addr));

   assert_reg_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req_valid && reg_ack |=> core_done && !core_busy);

   assert_miss_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      miss_req_valid && !miss_fill |=> miss_req_valid && $stable(miss_req_addr));

   assert_miss_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      miss_req_valid && miss_fill |=> core_done);

   assert_sig_resolve_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sig_query_valid |=> (core_done != miss_req_valid));

   assert_idle_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !core_busy && phase_end |=> core_busy && !core_done);

endmodule

// File: rtl/selfinv_coh_ctrl.sv
module selfinv_coh_ctrl
   import sic_pkg::*;
#(
   parameter  int ROWS        = 4,
   parameter  int COLS        = 4,
   parameter  int NUM_REGIONS = 4,
   parameter  int CORE_ID_W   = 4,
   parameter  int CORE_ID     = 5,
   localparam int WORDS       = ROWS * COLS,
   localparam int AW          = $clog2(WORDS),
   localparam int RW          = $clog2(NUM_REGIONS),
   localparam int RRW         = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   core_req_valid,
   input  logic                   core_req_write,
   input  logic                   core_req_atomic,
   input  logic [AW-1:0]          core_req_addr,
   input  logic [RW-1:0]          core_req_region,
   output logic                   core_busy,
   output logic                   core_done,
   output logic                   reg_req_valid,
   output logic [AW-1:0]          reg_req_addr,
   output logic [CORE_ID_W-1:0]   reg_req_core,
   input  logic                   reg_ack,
   output logic                   miss_req_valid,
   output logic [AW-1:0]          miss_req_addr,
   input  logic                   miss_fill,
   input  logic                   phase_end,
   input  logic [NUM_REGIONS-1:0] phase_wmask,
   output logic                   sweep_done,
   input  logic                   cs_start,
   output logic                   sig_query_valid,
   output logic [AW-1:0]          sig_query_addr,
   input  logic                   sig_hit
);

   if (ROWS < 1 || (ROWS & (ROWS - 1)) != 0) begin : g_chk_rows
      $error("ROWS must be a power of two");
   end
   if (COLS < 1 || (COLS & (COLS - 1)) != 0 || WORDS < 2) begin : g_chk_cols
      $error("COLS must be a power of two and the array at least two words");
   end
   if (NUM_REGIONS < 2 || (NUM_REGIONS & (NUM_REGIONS - 1)) != 0) begin : g_chk_reg
      $error("NUM_REGIONS must be a power of two, at least 2");
   end
   if (CORE_ID < 0 || CORE_ID >= (1 << CORE_ID_W)) begin : g_chk_id
      $error("CORE_ID does not fit CORE_ID_W");
   end

   word_st_e                rd_state;
   logic                    rd_touched;
   logic                    wr_en;
   logic [AW-1:0]           wr_addr;
   word_st_e                wr_state;
   logic [RW-1:0]           wr_region;
   logic                    touch_set;
   logic                    sweep_start;
   logic                    sweep_active;
   logic                    sweep_last;
   logic [RRW-1:0]          sweep_row;
   logic [NUM_REGIONS-1:0]  sweep_mask;

   assign reg_req_core = CORE_ID_W'(CORE_ID);

   sic_ctrl #(.AW(AW), .RW(RW)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .core_req_valid  (core_req_valid),
      .core_req_write  (core_req_write),
      .core_req_atomic (core_req_atomic),
      .core_req_addr   (core_req_addr),
      .core_req_region (core_req_region),
      .phase_end       (phase_end),
      .core_busy       (core_busy),
      .core_done       (core_done),
      .reg_req_valid   (reg_req_valid),
      .reg_req_addr    (reg_req_addr),
      .reg_ack         (reg_ack),
      .miss_req_valid  (miss_req_valid),
      .miss_req_addr   (miss_req_addr),
      .miss_fill       (miss_fill),
      .sig_query_valid (sig_query_valid),
      .sig_query_addr  (sig_query_addr),
      .sig_hit         (sig_hit),
      .rd_state        (rd_state),
      .rd_touched      (rd_touched),
      .wr_en           (wr_en),
      .wr_addr         (wr_addr),
      .wr_state        (wr_state),
      .wr_region       (wr_region),
      .touch_set       (touch_set),
      .sweep_start     (sweep_start),
      .sweep_last      (sweep_last)
   );

   sic_sweep_seq #(.ROWS(ROWS), .NUM_REGIONS(NUM_REGIONS)) u_sweep (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sweep_start),
      .mask_in (phase_wmask),
      .active  (sweep_active),
      .row     (sweep_row),
      .mask    (sweep_mask),
      .last    (sweep_last),
      .done    (sweep_done)
   );

   sic_word_array #(.ROWS(ROWS), .COLS(COLS), .NUM_REGIONS(NUM_REGIONS)) u_array (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_addr       (core_req_addr),
      .rd_state      (rd_state),
      .rd_touched    (rd_touched),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_state      (wr_state),
      .wr_region     (wr_region),
      .touch_set     (touch_set),
      .touch_addr    (core_req_addr),
      .touch_clr_all (cs_start),
      .sweep_en      (sweep_active),
      .sweep_row     (sweep_row),
      .sweep_mask    (sweep_mask)
   );

   // R10: the busy span covers every outstanding handshake
   assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req_valid || miss_req_valid || sig_query_valid || sweep_active) |-> core_busy);

   assert_sweep_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done |-> $past(core_busy));

endmodule

// File: tb/selfinv_coh_ctrl_bench.sv
`timescale 1ns/1ps
module selfinv_coh_ctrl_bench;

   localparam int ROWS = 4;
   localparam int COLS = 4;
   localparam int NW   = ROWS * COLS;
   localparam int NR   = 4;
   localparam int CID  = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       core_req_valid = 1'b0, core_req_write = 1'b0, core_req_atomic = 1'b0;
   logic [3:0] core_req_addr = '0;
   logic [1:0] core_req_region = '0;
   logic       core_busy, core_done;
   logic       reg_req_valid;
   logic [3:0] reg_req_addr;
   logic [3:0] reg_req_core;
   logic       reg_ack = 1'b0;
   logic       miss_req_valid;
   logic [3:0] miss_req_addr;
   logic       miss_fill = 1'b0;
   logic       phase_end = 1'b0;
   logic [3:0] phase_wmask = '0;
   logic       sweep_done;
   logic       cs_start = 1'b0;
   logic       sig_query_valid;
   logic [3:0] sig_query_addr;
   logic       sig_hit;
   bit         bsig [NW];

   assign sig_hit = sig_query_valid && bsig[sig_query_addr];

   always #4 clk = ~clk;

   selfinv_coh_ctrl #(.ROWS(ROWS), .COLS(COLS), .NUM_REGIONS(NR),
                      .CORE_ID_W(4), .CORE_ID(CID)) u_selfinv_coh_ctrl (.*);

   // behavioural reference: 0 idle, 1 registering, 2 missing, 3 querying, 4 sweeping
   int  m_mode = 0;
   int  m_st [NW];
   int  m_rg [NW];
   bit  m_tch [NW];
   int  m_addr = 0, m_reg = 0, m_row = 0;
   bit [3:0] m_mask = '0;
   bit  m_done = 0, m_sdone = 0;

   always @(posedge clk) begin
      m_done  = 0;
      m_sdone = 0;
      if (!rst_n) begin
         m_mode = 0; m_addr = 0; m_reg = 0; m_row = 0;
         foreach (m_st[i]) begin m_st[i] = 0; m_rg[i] = 0; m_tch[i] = 0; end
      end else begin
         case (m_mode)
            0: if (phase_end) begin
                  m_mode = 4; m_row = 0; m_mask = phase_wmask;
               end else if (core_req_valid) begin
                  m_addr = core_req_addr; m_reg = core_req_region;
                  if (core_req_write) begin
                     if (m_st[m_addr] == 2) m_done = 1;
                     else begin m_st[m_addr] = 2; m_rg[m_addr] = m_reg; m_mode = 1; end
                  end else begin
                     if (core_req_atomic && !m_tch[m_addr] && m_st[m_addr] == 1) m_mode = 3;
                     else if (m_st[m_addr] == 0) m_mode = 2;
                     else m_done = 1;
                     if (core_req_atomic) m_tch[m_addr] = 1;
                  end
               end
            1: if (reg_ack) begin m_mode = 0; m_done = 1; end
            2: if (miss_fill) begin
                  m_st[m_addr] = 1; m_rg[m_addr] = m_reg; m_mode = 0; m_done = 1;
               end
            3: if (bsig[m_addr]) begin m_st[m_addr] = 0; m_mode = 2; end
               else begin m_mode = 0; m_done = 1; end
            4: begin
                  for (int c = 0; c < COLS; c++) begin
                     int w;
                     w = m_row * COLS + c;
                     if (m_st[w] == 1 && m_mask[m_rg[w]]) m_st[w] = 0;
                  end
                  if (m_row == ROWS - 1) begin m_mode = 0; m_sdone = 1; end
                  else m_row++;
               end
            default: m_mode = 0;
         endcase
         if (cs_start) foreach (m_tch[i]) m_tch[i] = 0;
      end
   end

   int    n_cmp = 0, n_bad = 0, wd = 0, lat = 0, ack_cnt = 0, fill_cnt = 0;
   string tag = "R1";

   task automatic chk(string r, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s [%s] %s: actual %0d expected %0d at %0t", r, tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R10", "core_busy", core_busy, m_mode != 0);
      chk("R4",  "core_done", core_done, m_done);
      chk("R2",  "reg_req_valid", reg_req_valid, m_mode == 1);
      if (m_mode == 1) begin
         chk("R2", "reg_req_addr", reg_req_addr, m_addr);
         chk("R2", "reg_req_core", reg_req_core, CID);
      end
      chk("R3",  "miss_req_valid", miss_req_valid, m_mode == 2);
      if (m_mode == 2) chk("R3", "miss_req_addr", miss_req_addr, m_addr);
      chk("R6",  "sig_query_valid", sig_query_valid, m_mode == 3);
      if (m_mode == 3) chk("R6", "sig_query_addr", sig_query_addr, m_addr);
      chk("R5",  "sweep_done", sweep_done, m_sdone);
   endtask

   task automatic tick();
      @(negedge clk);
      if (rst_n) compare();
      if (reg_req_valid) ack_cnt++; else ack_cnt = 0;
      reg_ack = reg_req_valid && (ack_cnt > lat);
      if (miss_req_valid) fill_cnt++; else fill_cnt = 0;
      miss_fill = miss_req_valid && (fill_cnt > lat);
   endtask

   task automatic wait_idle();
      while (m_mode != 0) tick();
   endtask

   task automatic issue(bit w, bit at, int a, int r, string t);
      tag = t;
      wait_idle();
      core_req_valid = 1; core_req_write = w; core_req_atomic = at;
      core_req_addr = 4'(a); core_req_region = 2'(r);
      tick();
      core_req_valid = 0; core_req_write = 0; core_req_atomic = 0;
      wait_idle();
      tick();
   endtask

   task automatic sweep(bit [3:0] mask, string t);
      tag = t;
      wait_idle();
      phase_end = 1; phase_wmask = mask;
      tick();
      phase_end = 0;
      wait_idle();
      tick();
   endtask

   task automatic cs_pulse();
      cs_start = 1;
      tick();
      cs_start = 0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 20000) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual %0d expected %0d cycles", wd, 20000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      foreach (bsig[i]) bsig[i] = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      tag = "R1";
      chk("R1", "reset busy", core_busy, 0);
      chk("R1", "reset done", core_done, 0);
      chk("R1", "reset requests", reg_req_valid | miss_req_valid | sig_query_valid | sweep_done, 0);
      issue(0, 0, 0, 0, "R1");         // fresh word misses
      issue(0, 0, 3, 1, "R3");         // miss then Valid
      issue(0, 0, 3, 1, "R4");         // Valid hit
      issue(1, 0, 3, 1, "R2");         // Valid -> Registered
      issue(1, 0, 3, 1, "R2");         // already Registered: no request
      issue(0, 0, 3, 1, "R4");         // Registered hit
      lat = 3;
      issue(0, 0, 5, 2, "R3");
      issue(0, 0, 6, 1, "R3");
      issue(0, 0, 9, 0, "R3");
      issue(0, 0, 12, 1, "R3");
      lat = 0;
      sweep(4'b0010, "R5");            // drops 6 and 12, keeps 3, 5, 9
      issue(0, 0, 6, 1, "R5");
      issue(0, 0, 5, 2, "R5");
      issue(0, 0, 3, 1, "R5");
      issue(0, 0, 12, 1, "R5");
      // request colliding with phase_end is not accepted
      tag = "R5";
      wait_idle();
      phase_end = 1; phase_wmask = 4'b0001;
      core_req_valid = 1; core_req_write = 1; core_req_addr = 4'd9;
      tick();
      phase_end = 0; core_req_valid = 0; core_req_write = 0;
      wait_idle(); tick();
      issue(0, 0, 9, 0, "R5");         // 9 swept, still not Registered
      cs_pulse();
      bsig[5] = 1;
      issue(0, 1, 5, 2, "R6");         // query hits: drop and refetch
      issue(0, 1, 5, 2, "R8");         // touched: no query
      issue(0, 1, 3, 1, "R7");         // Registered: no query
      bsig[6] = 0;
      issue(0, 1, 6, 1, "R6");         // query misses: done
      cs_pulse();
      issue(0, 1, 5, 2, "R9");         // cleared: queries again
      // touched set and cleared in the same cycle: clear wins
      tag = "R9";
      wait_idle();
      cs_start = 1; core_req_valid = 1; core_req_atomic = 1; core_req_addr = 4'd6; core_req_region = 2'd1;
      tick();
      cs_start = 0; core_req_valid = 0; core_req_atomic = 0;
      wait_idle(); tick();
      issue(0, 1, 6, 1, "R9");
      // requests while busy are ignored
      lat = 4;
      tag = "R10";
      wait_idle();
      core_req_valid = 1; core_req_addr = 4'd14; core_req_region = 2'd3;
      tick();
      core_req_write = 1; core_req_addr = 4'd15;
      tick(); tick();
      core_req_valid = 0; core_req_write = 0;
      wait_idle(); tick();
      lat = 0;
      issue(0, 0, 15, 3, "R10");       // still Invalid: misses
      issue(1, 0, 14, 3, "R2");
      sweep(4'b1111, "R5");
      issue(0, 0, 14, 3, "R5");        // Registered survives
      issue(0, 0, 15, 3, "R5");        // Valid dropped
      repeat (3) tick();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule